// File: doc/BRIEF.md
# NAND Flash Host Window

This block lets a byte-wide host bus drive a raw NAND flash device through a relocatable 256-byte register window. A fixed configuration page holds two things: an enable flag and a full-width base address for the window. While the window is enabled, any access whose page address equals the stored base is decoded into the window's registers. The configuration page always takes priority over the window.

Inside the window the host finds a data port, a mode register, a status byte and an interrupt status/mask pair. The data port is mirrored on the first four offsets. A data-port write sends a byte to the flash with a one-cycle write strobe. A data-port read returns the flash's data-in byte and raises a read strobe in the same cycle. The mode register drives the flash control pins directly. It also selects an ECC mode; selecting the enable or clear mode emits a one-cycle reset pulse for an external ECC accumulator. Every data-port write sets bit 0 of the interrupt status. One interrupt line is raised from the status and mask registers, gated by a global enable bit in the mask.

Read data is combinational in the cycle of the request. Register writes take effect at the clock edge that ends the request cycle.

Top module: `nand_host_window`

## Requirements
- R1: Configuration page 0x01, offset 0x04: bit 1 of a write sets or clears the window enable. A read there returns 0x02 when the window is enabled and 0x00 when it is not.
- R2: Configuration offsets 0x10 to 0x13 each hold one byte of the 32-bit window base, least significant byte at 0x10. Each byte can be written and read back.
- R3: A window access is decoded only when the window is enabled and the access address with its low 8 bits cleared equals the stored base. Configuration-page addresses are never window accesses. Any other access leaves all state and strobes unchanged, and a read of it returns 0x00.
- R4: Window offset 0x04 is the mode register and reads back as written. Mode bits drive the pins from the cycle after the write: bit 0 drives command-latch, bit 1 drives address-latch, bit 7 drives write-protect, and chip-enable is the inverse of bit 4.
- R5: Window offsets 0x00 to 0x03 are the data port. A write drives the byte on nand_dout_o with nand_wr_o high for exactly the next cycle. A read returns nand_din_i with nand_rd_o high in the same cycle.
- R6: ecc_mode_o is mode bits 6:5 (00 off, 01 enable, 10 read, 11 clear). A mode write selecting 01 or 11 gives a one-cycle pulse on ecc_rst_o in the next cycle. A mode write selecting 00 or 10 gives no pulse.
- R7: Window offset 0x05 always reads 0x14.
- R8: Window offset 0x06 is interrupt status and offset 0x07 is interrupt mask. Both read back as written. A data-port write sets status bit 0 and leaves the other status bits unchanged.
- R9: From the cycle after any status, mask or data write, irq_o is high exactly when mask bit 7 is set and (mask AND status) is nonzero.
- R10: After reset the window is disabled, the base is 0, and the mode, status and mask are 0. So chip-enable is high, the other pins are low, and irq_o is low.
- R11: Unlisted configuration offsets and window offsets 0x08 to 0xFF read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Host byte address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid in the request cycle |
| nand_dout_o | output | 8 | Byte sent to the flash |
| nand_wr_o | output | 1 | Flash write strobe |
| nand_din_i | input | 8 | Byte returned by the flash |
| nand_rd_o | output | 1 | Flash read strobe |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_ce_o | output | 1 | Chip enable (inverse of mode bit 4) |
| nand_wp_o | output | 1 | Write protect |
| ecc_mode_o | output | 2 | Selected ECC mode |
| ecc_rst_o | output | 1 | ECC accumulator reset pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted enable or base byte shows up on the very next window access. Either a read returns 0x00 instead of the mode value, or a data write gives no write strobe. A wrong mode bit is visible on the pin outputs one cycle after the mode write. A wrong status or mask bit shows in irq_o one cycle after the write that should have settled it. A lost status-bit-0 set shows in the next status read. Sweeping all 256 mode values, and mask values against a spread of status values, makes every such fault visible within two cycles of the stimulus that exposes it.

// File: rtl/nhw_pkg.sv
package nhw_pkg;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned BYTE_W = 8;

  // configuration page offsets
  localparam logic [PAGE_W-1:0] CFG_CTRL_OFF = 8'h04;
  localparam logic [PAGE_W-1:0] CFG_BASE_OFF = 8'h10;

  // window offsets
  localparam logic [PAGE_W-1:0] WIN_MODE_OFF = 8'h04;
  localparam logic [PAGE_W-1:0] WIN_STAT_OFF = 8'h05;
  localparam logic [PAGE_W-1:0] WIN_ISR_OFF  = 8'h06;
  localparam logic [PAGE_W-1:0] WIN_IMR_OFF  = 8'h07;

  localparam logic [BYTE_W-1:0] STATUS_VAL = 8'h14;

  typedef enum logic [1:0] {
    ECC_OFF = 2'b00,
    ECC_ON  = 2'b01,
    ECC_RD  = 2'b10,
    ECC_CLR = 2'b11
  } ecc_sel_e;

  // mode register bit positions
  localparam int unsigned MB_CLE = 0;
  localparam int unsigned MB_ALE = 1;
  localparam int unsigned MB_CEOFF = 4;
  localparam int unsigned MB_ECC_LO = 5;
  localparam int unsigned MB_WP = 7;
endpackage

// File: rtl/nhw_cfg.sv
module nhw_cfg
  import nhw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] off_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              en_o,
  output logic [AW-1:0]     base_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned NLANE = AW / BYTE_W;

  logic en_q;
  logic [BYTE_W-1:0] lane_rd [NLANE];
  logic [NLANE-1:0]  lane_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        en_q <= 1'b0;
    else if (wr_i && off_i == CFG_CTRL_OFF) en_q <= wdata_i[1];
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    assign lane_hit[g] = (off_i == CFG_BASE_OFF + PAGE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lane_q <= '0;
      else if (wr_i && lane_hit[g]) lane_q <= wdata_i;
    end
    assign base_o[g*BYTE_W +: BYTE_W] = lane_q;
    assign lane_rd[g] = lane_hit[g] ? lane_q : '0;

    // R2: a lane write lands in that byte of the base
    a_r2_lane_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && lane_hit[g]) |=> (base_o[g*BYTE_W +: BYTE_W] == $past(wdata_i)));
  end

  always_comb begin
    rdata_o = (off_i == CFG_CTRL_OFF) ? {6'b0, en_q, 1'b0} : '0;
    for (int i = 0; i < NLANE; i++) rdata_o |= lane_rd[i];
  end

  assign en_o = en_q;

  // R1: enable follows bit 1 of a control write
  a_r1_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == CFG_CTRL_OFF) |=> (en_o == $past(wdata_i[1])));
endmodule

// File: rtl/nhw_regs.sv
module nhw_regs
  import nhw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PAGE_W-1:0] off_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] nand_dout_o,
  output logic              nand_wr_o,
  input  logic [BYTE_W-1:0] nand_din_i,
  output logic              nand_rd_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_ce_o,
  output logic              nand_wp_o,
  output logic [1:0]        ecc_mode_o,
  output logic              ecc_rst_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] mode_q, isr_q, imr_q, dout_q;
  logic wr_q, ecc_rst_q;
  logic data_hit, wr_data, wr_mode, wr_isr, wr_imr;
  ecc_sel_e ecc_sel, ecc_new;

  assign data_hit = (off_i[PAGE_W-1:2] == '0);
  assign wr_data  = wr_i && data_hit;
  assign wr_mode  = wr_i && off_i == WIN_MODE_OFF;
  assign wr_isr   = wr_i && off_i == WIN_ISR_OFF;
  assign wr_imr   = wr_i && off_i == WIN_IMR_OFF;
  assign ecc_new  = ecc_sel_e'(wdata_i[MB_ECC_LO +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      isr_q     <= '0;
      imr_q     <= '0;
      dout_q    <= '0;
      wr_q      <= 1'b0;
      ecc_rst_q <= 1'b0;
    end else begin
      wr_q      <= wr_data;
      ecc_rst_q <= wr_mode && (ecc_new == ECC_ON || ecc_new == ECC_CLR);
      if (wr_mode) mode_q <= wdata_i;
      if (wr_data) dout_q <= wdata_i;
      if (wr_imr)  imr_q  <= wdata_i;
      if (wr_isr)       isr_q    <= wdata_i;
      else if (wr_data) isr_q[0] <= 1'b1;
    end
  end

  assign ecc_sel = ecc_sel_e'(mode_q[MB_ECC_LO +: 2]);

  always_comb begin
    unique case (1'b1)
      data_hit:                 rdata_o = nand_din_i;
      off_i == WIN_MODE_OFF:    rdata_o = mode_q;
      off_i == WIN_STAT_OFF:    rdata_o = STATUS_VAL;
      off_i == WIN_ISR_OFF:     rdata_o = isr_q;
      off_i == WIN_IMR_OFF:     rdata_o = imr_q;
      default:                  rdata_o = '0;
    endcase
    if (!rd_i) rdata_o = '0;
  end

  assign nand_rd_o   = rd_i && data_hit;
  assign nand_wr_o   = wr_q;
  assign nand_dout_o = dout_q;
  assign nand_cle_o  = mode_q[MB_CLE];
  assign nand_ale_o  = mode_q[MB_ALE];
  assign nand_ce_o   = ~mode_q[MB_CEOFF];
  assign nand_wp_o   = mode_q[MB_WP];
  assign ecc_mode_o  = ecc_sel;
  assign ecc_rst_o   = ecc_rst_q;
  assign irq_o       = imr_q[7] && |(imr_q & isr_q);

  // R4: chip enable is the inverse of the written bit 4
  a_r4_ce_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> (nand_ce_o == !$past(wdata_i[MB_CEOFF])));
  // R5: write strobe only after a data-port write, carrying its byte
  a_r5_wr_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (nand_wr_o && nand_dout_o == $past(wdata_i)));
  a_r5_wr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_wr_o |-> $past(wr_data));
  // R6: ecc reset pulse only after a mode write selecting enable or clear
  a_r6_ecc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_rst_o |-> ($past(wr_mode) && $past(wdata_i[MB_ECC_LO])));
  // R8: data write sets status bit 0
  a_r8_isr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> isr_q[0]);
  // R9: the interrupt only rises after a register write
  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr_i));
endmodule

// File: rtl/nand_host_window.sv
module nand_host_window
  import nhw_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned CFG_PAGE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    nand_dout_o,
  output logic          nand_wr_o,
  input  logic [7:0]    nand_din_i,
  output logic          nand_rd_o,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic          nand_ce_o,
  output logic          nand_wp_o,
  output logic [1:0]    ecc_mode_o,
  output logic          ecc_rst_o,
  output logic          irq_o
);
  localparam int unsigned PG_W = AW - PAGE_W;

  logic [PG_W-1:0]   page;
  logic [PAGE_W-1:0] off;
  logic              cfg_hit, win_hit, win_en;
  logic [AW-1:0]     win_base;
  logic [BYTE_W-1:0] cfg_rdata, win_rdata;

  assign page    = addr_i[AW-1:PAGE_W];
  assign off     = addr_i[PAGE_W-1:0];
  assign cfg_hit = (page == PG_W'(CFG_PAGE));
  assign win_hit = !cfg_hit && win_en && ({page, {PAGE_W{1'b0}}} == win_base);

  nhw_cfg #(.AW(AW)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_i && we_i && cfg_hit),
    .off_i   (off),
    .wdata_i (wdata_i),
    .en_o    (win_en),
    .base_o  (win_base),
    .rdata_o (cfg_rdata)
  );

  nhw_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (req_i && we_i && win_hit),
    .rd_i        (req_i && !we_i && win_hit),
    .off_i       (off),
    .wdata_i     (wdata_i),
    .rdata_o     (win_rdata),
    .nand_dout_o (nand_dout_o),
    .nand_wr_o   (nand_wr_o),
    .nand_din_i  (nand_din_i),
    .nand_rd_o   (nand_rd_o),
    .nand_cle_o  (nand_cle_o),
    .nand_ale_o  (nand_ale_o),
    .nand_ce_o   (nand_ce_o),
    .nand_wp_o   (nand_wp_o),
    .ecc_mode_o  (ecc_mode_o),
    .ecc_rst_o   (ecc_rst_o),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (cfg_hit)      rdata_o = cfg_rdata;
      else if (win_hit) rdata_o = win_rdata;
    end
  end

  // R3: a write outside the window gives no flash strobe
  a_r3_no_stray_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !win_hit) |=> !nand_wr_o);
  // R3: read strobe only inside an enabled window
  a_r3_rd_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_rd_o |-> (req_i && !we_i && win_en));
  // R10: pins leave reset at their idle values
  a_r10_reset_idle: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (nand_ce_o && !irq_o && !nand_wr_o));
endmodule

// File: tb/test_nand_host_window.sv
`timescale 1ns/1ps
module test_nand_host_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0, din = 8'h00;
  logic [7:0]  rdata, dout;
  logic        nwr, nrd, cle, ale, ce, wp, ecc_rst, irq;
  logic [1:0]  ecc_mode;
  int          n_chk = 0, n_bad = 0;

  localparam logic [31:0] CFG = 32'h0000_0100;
  localparam logic [31:0] WIN = 32'h1234_5600;

  always #2 clk = ~clk;

  nand_host_window i_nand_host_window (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .nand_dout_o(dout), .nand_wr_o(nwr),
    .nand_din_i(din), .nand_rd_o(nrd), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_ce_o(ce), .nand_wp_o(wp), .ecc_mode_o(ecc_mode),
    .ecc_rst_o(ecc_rst), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [7:0] d, output logic rs);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1; d = rdata; rs = nrd;
    @(posedge clk); #1; req = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic rs;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 pins {ce,cle,ale,wp,irq,wr,ecc}", {ce, cle, ale, wp, irq, nwr, ecc_rst, ecc_mode},
        {1'b1, 6'b0, 2'b0});
    rst_n = 1'b1;
    bus_rd(CFG + 32'h04, d, rs); chk("R10 enable clear", d, 8'h00);
    bus_rd(CFG + 32'h10, d, rs); chk("R10 base clear", d, 8'h00);

    // R2 base lanes
    bus_wr(CFG + 32'h10, WIN[7:0]);
    bus_wr(CFG + 32'h11, WIN[15:8]);
    bus_wr(CFG + 32'h12, WIN[23:16]);
    bus_wr(CFG + 32'h13, WIN[31:24]);
    for (int k = 0; k < 4; k++) begin
      bus_rd(CFG + 32'h10 + k, d, rs);
      chk("R2 base lane", d, WIN[k*8 +: 8]);
    end

    // R3 disabled window: write ignored, read zero, no strobes
    bus_wr(WIN + 32'h04, 8'h83);
    chk("R3 disabled pins", {cle, ale, wp}, 3'b000);
    bus_wr(WIN + 32'h00, 8'h5A);
    chk("R3 disabled write strobe", nwr, 1'b0);
    din = 8'hC3;
    bus_rd(WIN + 32'h00, d, rs);
    chk("R3 disabled read", {rs, d}, 9'h000);

    // R1 enable
    bus_wr(CFG + 32'h04, 8'hFD);
    bus_rd(CFG + 32'h04, d, rs); chk("R1 bit1 clear", d, 8'h00);
    bus_wr(CFG + 32'h04, 8'h02);
    bus_rd(CFG + 32'h04, d, rs); chk("R1 enabled reads 2", d, 8'h02);
    bus_rd(WIN + 32'h04, d, rs); chk("R3 earlier write ignored", d, 8'h00);
    bus_rd(WIN + 32'h06, d, rs); chk("R3 earlier data write left isr", d, 8'h00);

    // R3 other page does not hit
    bus_wr(WIN + 32'h104, 8'h01);
    chk("R3 other page", cle, 1'b0);
    // R3 base with nonzero low byte never matches
    bus_wr(CFG + 32'h10, 8'h01);
    bus_rd(WIN + 32'h05, d, rs); chk("R3 misaligned base", d, 8'h00);
    bus_rd(WIN + 32'h01 - 32'h01 + 32'h01, d, rs); chk("R3 misaligned exact addr", d, 8'h00);
    bus_wr(CFG + 32'h10, 8'h00);

    // R7 status
    bus_rd(WIN + 32'h05, d, rs); chk("R7 status", d, 8'h14);

    // R5 data port on all four offsets
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = 8'h11 * (k + 3);
      bus_wr(WIN + k, v);
      chk("R5 write strobe+byte", {nwr, dout}, {1'b1, v});
      @(posedge clk); #1;
      chk("R5 strobe one cycle", nwr, 1'b0);
      din = ~v;
      bus_rd(WIN + k, d, rs);
      chk("R5 read data+strobe", {rs, d}, {1'b1, ~v});
    end

    // R4 / R6 mode sweep
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mv;
      mv = 8'(m);
      bus_wr(WIN + 32'h04, mv);
      chk("R4 pins {cle,ale,wp,ce}", {cle, ale, wp, ce}, {mv[0], mv[1], mv[7], ~mv[4]});
      chk("R6 ecc mode+pulse", {ecc_mode, ecc_rst}, {mv[6:5], mv[5:5]});
      bus_rd(WIN + 32'h04, d, rs);
      chk("R4 mode readback", d, mv);
      chk("R6 pulse one cycle", ecc_rst, 1'b0);
    end

    // R8 status set by data write
    bus_wr(WIN + 32'h06, 8'h00);
    bus_wr(WIN + 32'h02, 8'h77);
    bus_rd(WIN + 32'h06, d, rs); chk("R8 data write sets bit0", d, 8'h01);
    bus_wr(WIN + 32'h06, 8'hA4);
    bus_wr(WIN + 32'h00, 8'h01);
    bus_rd(WIN + 32'h06, d, rs); chk("R8 other bits kept", d, 8'hA5);
    bus_wr(WIN + 32'h07, 8'h3C);
    bus_rd(WIN + 32'h07, d, rs); chk("R8 mask readback", d, 8'h3C);

    // R9 interrupt sweep
    for (int s = 0; s < 16; s++) begin
      for (int mk = 0; mk < 256; mk++) begin
        logic [7:0] sv, kv;
        sv = 8'(s * 17);
        kv = 8'(mk);
        bus_wr(WIN + 32'h06, sv);
        bus_wr(WIN + 32'h07, kv);
        chk("R9 irq", irq, kv[7] && ((kv & sv) != 8'h00));
      end
    end
    // R9 data write raises irq
    bus_wr(WIN + 32'h06, 8'h00);
    bus_wr(WIN + 32'h07, 8'h81);
    chk("R9 irq low before data", irq, 1'b0);
    bus_wr(WIN + 32'h03, 8'h00);
    chk("R9 irq after data write", irq, 1'b1);

    // R11 unmapped offsets
    bus_wr(CFG + 32'h20, 8'hFF);
    bus_rd(CFG + 32'h20, d, rs); chk("R11 cfg unmapped", d, 8'h00);
    bus_rd(CFG + 32'h04, d, rs); chk("R11 enable untouched", d, 8'h02);
    bus_wr(WIN + 32'h08, 8'hFF);
    bus_rd(WIN + 32'h08, d, rs); chk("R11 window unmapped", {rs, d}, 9'h000);
    bus_rd(WIN + 32'h04, d, rs); chk("R11 mode untouched", d, 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule